// File: doc/BRIEF.md
# Dual-Port RAM with Deterministic Collision Policy

This block is a synchronous true dual-port memory. Both ports run from one clock and read on every cycle. Each port has its own address, write enable, write data and registered read data. Both ports work in write-first mode: a port that writes a word shows that same word on its own output one cycle later.

Its distinctive feature is a fixed, asymmetric rule for the case where both ports use the same address in the same cycle. A write from port A is forwarded to a port B read of that address. A write from port B is not forwarded to port A, so A sees the word that was stored before. If both ports write the same address, port B's word is the one kept. Because this rule is fixed, a sliding-window filter that streams rows through the memory can depend on it and needs no bypass multiplexers or extra registers outside the RAM.

Storage is cleared by the reset. The reset is asserted asynchronously and released synchronously inside the block. The read registers have no reset and load on every clock.

Top module: `dpr_collide_ram`

## Requirements
- R1: Once reset has been released, every location reads as zero on both ports until it is written.
- R2: When port A writes, `a_rdata` in the next cycle equals the `a_wdata` just written (write-first).
- R3: When port B writes, `b_rdata` in the next cycle equals the `b_wdata` just written (write-first).
- R4: A read with no write on either port returns the word most recently stored at that address, one cycle after the address is presented.
- R5: When port A writes an address that port B reads without writing in the same cycle, `b_rdata` in the next cycle shows A's new word.
- R6: When port B writes an address that port A reads without writing in the same cycle, `a_rdata` in the next cycle shows the word stored before B's write. A later read then returns B's word.
- R7: When both ports write one address in the same cycle, port B's word is stored. Each port shows its own written word in the next cycle.
- R8: A write of 0 followed in the next cycle by a write of 1 to the same address on one port gives 1 on that port's output in the cycle after.
- R9: Writes from both ports to different addresses in the same cycle are both stored.
- R10: No read enable exists. Each output updates on every clock, one cycle after its address changes, including across long mixed sequences of reads, writes and collisions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock shared by both ports |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block; clears storage |
| a_addr | input | ADDR_W | Port A word address |
| a_we | input | 1 | Port A write enable |
| a_wdata | input | WIDTH | Port A write data |
| a_rdata | output | WIDTH | Port A registered read data |
| b_addr | input | ADDR_W | Port B word address |
| b_we | input | 1 | Port B write enable |
| b_wdata | input | WIDTH | Port B write data |
| b_rdata | output | WIDTH | Port B registered read data |

## Verification
The bound checker checks on every cycle the rules that can be seen from the ports alone. These are write-first on each port, forwarding of an A write to a same-address B read, and each port showing its own word when both write the same address. The rules that depend on the stored contents need the bench's reference model, which tracks memory state. These are B's write staying hidden from A's same-cycle read, B winning the stored value in a double write, zero contents after reset and independent writes to different addresses. The bench checks them through directed sequences and a long random run on a few addresses, where collisions are frequent.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Selects where a port's next read word comes from.
  typedef enum logic [1:0] {
    SRC_STORE = 2'd0,
    SRC_OWN   = 2'd1,
    SRC_PEER  = 2'd2
  } dpr_src_e;

  // One port's request, packed for generate-loop wiring.
  typedef struct packed {
    logic we;
  } dpr_ctl_t;

endpackage

// File: rtl/dpr_reset_sync.sv
module dpr_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int DEPTH  = 1024,
  parameter int WIDTH  = 18,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [WIDTH-1:0]  a_wdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [WIDTH-1:0]  b_wdata,
  output logic [WIDTH-1:0]  a_stored,
  output logic [WIDTH-1:0]  b_stored
);

  logic [WIDTH-1:0] cells_q [DEPTH];
  logic             same_addr;
  logic             a_wr_en;
  logic             b_wr_en;

  // Port B owns the word on a double write to one address.
  always_comb begin
    same_addr = (a_addr == b_addr);
    a_wr_en   = a_we & ~(b_we & same_addr);
    b_wr_en   = b_we;
  end

  // Read the contents from before this edge (old data).
  always_comb begin
    a_stored = cells_q[a_addr];
    b_stored = cells_q[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells_q[i] <= '0;
      end
    end else begin
      if (a_wr_en) begin
        cells_q[a_addr] <= a_wdata;
      end
      if (b_wr_en) begin
        cells_q[b_addr] <= b_wdata;
      end
    end
  end

endmodule

// File: rtl/dpr_rd_port.sv
module dpr_rd_port
  import dpr_pkg::*;
#(
  parameter int WIDTH        = 18,
  parameter int ADDR_W       = 10,
  parameter bit PEER_VISIBLE = 1'b0
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              own_we,
  input  logic [WIDTH-1:0]  own_wdata,
  input  logic [ADDR_W-1:0] peer_addr,
  input  logic              peer_we,
  input  logic [WIDTH-1:0]  peer_wdata,
  input  logic [WIDTH-1:0]  stored,
  output logic [WIDTH-1:0]  rdata
);

  dpr_src_e         src_sel;
  logic             peer_hit;
  logic [WIDTH-1:0] rdata_d;
  logic [WIDTH-1:0] rdata_q;

  always_comb begin
    peer_hit = peer_we & (peer_addr == own_addr);
    if (own_we) begin
      src_sel = SRC_OWN;
    end else if (peer_hit && PEER_VISIBLE) begin
      src_sel = SRC_PEER;
    end else begin
      src_sel = SRC_STORE;
    end
  end

  always_comb begin
    unique case (src_sel)
      SRC_OWN:  rdata_d = own_wdata;
      SRC_PEER: rdata_d = peer_wdata;
      default:  rdata_d = stored;
    endcase
  end

  // Read register: loads every cycle, no reset.
  always_ff @(posedge clk) begin
    rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/dpr_collide_ram.sv
module dpr_collide_ram #(
  parameter int DEPTH  = 1024,
  parameter int WIDTH  = 18,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [WIDTH-1:0]  a_wdata,
  output logic [WIDTH-1:0]  a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [WIDTH-1:0]  b_wdata,
  output logic [WIDTH-1:0]  b_rdata
);

  localparam int NPORT = 2;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] p_addr  [NPORT];
  logic              p_we    [NPORT];
  logic [WIDTH-1:0]  p_wdata [NPORT];
  logic [WIDTH-1:0]  p_store [NPORT];
  logic [WIDTH-1:0]  p_rdata [NPORT];

  always_comb begin
    p_addr[0]  = a_addr;
    p_we[0]    = a_we;
    p_wdata[0] = a_wdata;
    p_addr[1]  = b_addr;
    p_we[1]    = b_we;
    p_wdata[1] = b_wdata;
  end

  dpr_reset_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dpr_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .a_addr   (a_addr),
    .a_we     (a_we),
    .a_wdata  (a_wdata),
    .b_addr   (b_addr),
    .b_we     (b_we),
    .b_wdata  (b_wdata),
    .a_stored (p_store[0]),
    .b_stored (p_store[1])
  );

  // Port 1 (B) sees port 0 (A) writes; port 0 does not see port 1.
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dpr_rd_port #(
      .WIDTH        (WIDTH),
      .ADDR_W       (ADDR_W),
      .PEER_VISIBLE (g == 1)
    ) port_i (
      .clk        (clk),
      .own_addr   (p_addr[g]),
      .own_we     (p_we[g]),
      .own_wdata  (p_wdata[g]),
      .peer_addr  (p_addr[NPORT-1-g]),
      .peer_we    (p_we[NPORT-1-g]),
      .peer_wdata (p_wdata[NPORT-1-g]),
      .stored     (p_store[g]),
      .rdata      (p_rdata[g])
    );
  end

  assign a_rdata = p_rdata[0];
  assign b_rdata = p_rdata[1];

endmodule

// File: rtl/dpr_collide_chk.sv
module dpr_collide_chk #(
  parameter int WIDTH  = 18,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_q,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_we,
  input logic [WIDTH-1:0]  a_wdata,
  input logic [WIDTH-1:0]  a_rdata,
  input logic [ADDR_W-1:0] b_addr,
  input logic              b_we,
  input logic [WIDTH-1:0]  b_wdata,
  input logic [WIDTH-1:0]  b_rdata
);

  AST_A_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_q)
    a_we |=> (a_rdata == $past(a_wdata))); // R2

  AST_B_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_q)
    b_we |=> (b_rdata == $past(b_wdata))); // R3

  AST_A_TO_B_FORWARD: assert property (@(posedge clk) disable iff (!rst_q)
    (a_we && !b_we && (a_addr == b_addr)) |=> (b_rdata == $past(a_wdata))); // R5

  AST_DUAL_WRITE_OWN: assert property (@(posedge clk) disable iff (!rst_q)
    (a_we && b_we && (a_addr == b_addr))
      |=> ((a_rdata == $past(a_wdata)) && (b_rdata == $past(b_wdata)))); // R7

  AST_ZERO_THEN_ONE: assert property (@(posedge clk) disable iff (!rst_q)
    (a_we && $past(a_we) && (a_addr == $past(a_addr)) && (a_wdata == 1) && ($past(a_wdata) == 0))
      |=> (a_rdata == 1)); // R8

endmodule

bind dpr_collide_ram dpr_collide_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst_q   (rst_sync_n),
  .a_addr  (a_addr),
  .a_we    (a_we),
  .a_wdata (a_wdata),
  .a_rdata (a_rdata),
  .b_addr  (b_addr),
  .b_we    (b_we),
  .b_wdata (b_wdata),
  .b_rdata (b_rdata)
);

// File: tb/dpr_collide_ram_tb_top.sv
`timescale 1ns/1ps
module dpr_collide_ram_tb_top;

  localparam int DEPTH  = 1024;
  localparam int WIDTH  = 18;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic              a_we, b_we;
  logic [WIDTH-1:0]  a_wdata, b_wdata;
  logic [WIDTH-1:0]  a_rdata, b_rdata;

  always #2.5 clk = ~clk;

  dpr_collide_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  int total = 0;
  int bad   = 0;
  bit chk_on = 1'b0;
  bit exp_on = 1'b0;
  string cur_tag = "R1";
  string exp_tag = "R1";
  logic [WIDTH-1:0] ref_mem [DEPTH];
  logic [WIDTH-1:0] exp_a, exp_b;

  // Behavioural reference: resolves each cycle from the requirements.
  always @(posedge clk) begin
    if (rst_n) begin
      exp_a = a_we ? a_wdata : ref_mem[a_addr];
      if (b_we)                              exp_b = b_wdata;
      else if (a_we && (a_addr == b_addr))   exp_b = a_wdata;
      else                                   exp_b = ref_mem[b_addr];
      if (a_we) ref_mem[a_addr] = a_wdata;
      if (b_we) ref_mem[b_addr] = b_wdata;
      exp_tag = cur_tag;
      exp_on  = chk_on;
    end
  end

  always @(negedge clk) begin
    if (exp_on) begin
      total++;
      if (a_rdata !== exp_a) begin
        bad++;
        $display("FAIL %s port A: actual=%h expected=%h", exp_tag, a_rdata, exp_a);
      end
      total++;
      if (b_rdata !== exp_b) begin
        bad++;
        $display("FAIL %s port B: actual=%h expected=%h", exp_tag, b_rdata, exp_b);
      end
    end
  end

  task automatic cyc(input bit aw, input int aa, input int ad,
                     input bit bw, input int ba, input int bd, input string tag);
    @(negedge clk);
    a_we = aw; a_addr = ADDR_W'(aa); a_wdata = WIDTH'(ad);
    b_we = bw; b_addr = ADDR_W'(ba); b_wdata = WIDTH'(bd);
    cur_tag = tag;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    rst_n = 1'b0;
    a_we = 0; b_we = 0; a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;

    // R1: zero contents after reset, low and top addresses
    for (int i = 0; i < 16; i++) cyc(0, i, 0, 0, 15 - i, 0, "R1");
    cyc(0, DEPTH - 1, 0, 0, DEPTH - 1, 0, "R1");

    // R2 / R3: write-first on each port, different addresses (R9)
    cyc(1, 10, 'h1234, 1, 20, 'h2abc, "R9");
    cyc(1, 11, 'h3fff0, 0, 10, 0, "R2");
    cyc(0, 20, 0, 1, 21, 'h0555, "R3");
    // R4: plain reads return stored words
    cyc(0, 10, 0, 0, 20, 0, "R4");
    cyc(0, 21, 0, 0, 11, 0, "R4");

    // R5: A writes, B reads same address
    cyc(1, 30, 'h0aaaa, 0, 30, 0, "R5");
    cyc(0, 30, 0, 0, 30, 0, "R4");

    // R6: B writes, A reads same address: A sees old word, later B's
    cyc(1, 40, 'h00111, 0, 0, 0, "R2");
    cyc(0, 40, 0, 1, 40, 'h00222, "R6");
    cyc(0, 40, 0, 0, 40, 0, "R6");

    // R7: both write same address; B's word stored
    cyc(1, 50, 'h0f0f0, 1, 50, 'h30303, "R7");
    cyc(0, 50, 0, 0, 50, 0, "R7");

    // R8: write 0 then 1 on each port
    cyc(1, 60, 0, 0, 61, 0, "R8");
    cyc(1, 60, 1, 0, 61, 0, "R8");
    cyc(0, 61, 0, 1, 61, 0, "R8");
    cyc(0, 61, 0, 1, 61, 1, "R8");
    cyc(0, 60, 0, 0, 61, 0, "R8");

    // R10: long random mix on few addresses, dense collisions
    for (int i = 0; i < 600; i++) begin
      cyc($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 262143),
          $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 262143), "R10");
    end
    cyc(0, 0, 0, 0, 1, 0, "R10");
    cyc(0, 2, 0, 0, 3, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule